// File: doc/BRIEF.md
# Reduced-ISA Decode and Branch-Resolve Stage

This block is the second stage of a five-stage in-order pipeline for a small RISC-V integer subset. Each cycle it takes the instruction word, its program counter and a valid flag from the fetch/decode register. It addresses two register-file read ports and receives two 64-bit operands in the same cycle. At the clock edge it loads the decode-to-execute register: the operands, the register indices, a sign-extended immediate, and the control bits that the later stages need (add/subtract select, logic-function code, immediate-operand flag, register write enable, memory read, memory write).

Control flow is settled here rather than in execute. The conditional branch opcode has inverted sense: it is taken when the two operands differ. It is resolved by comparing the two register values and adding the branch offset to the branch's own PC. The unconditional jump always redirects. A redirect is a combinational request with a target address, sent back to fetch in the same cycle. The stage then discards the one instruction that fetch had already issued from the fall-through address. An all-ones word is a halt marker. It is reported on its own output and travels down the pipe as a bubble.

Top module: `rvd_decode_stage`

## Requirements
- R1: While reset is high and on the first cycle after it, `ex_valid_o`, `ex_wr_en_o`, `ex_mem_rd_o` and `ex_mem_wr_o` are 0.
- R2: Register ops (opcode 0110011) are recognised for these funct7/funct3 pairs: add 0000000/000, sub 0100000/000, and 0000000/111, or 0000000/110, xor 0000000/100. Each sets write enable and clears the immediate flag. `ex_alu_add_o` is 1 only for add. `ex_alu_fn_o` is 00 for add/sub, 01 and, 10 or, 11 xor. `ex_rd_o` = instr[11:7].
- R3: addi (0010011, funct3 000) and ld (0000011, funct3 011) set write enable, add select and the immediate flag. `ex_imm_o` is instr[31:20] sign-extended. Only ld sets memory read.
- R4: sd (0100011, funct3 011) sets memory write and add select, and clears write enable and memory read. `ex_imm_o` is {instr[31:25], instr[11:7]} sign-extended.
- R5: `rf_raddr1_o` = instr[19:15] and `rf_raddr2_o` = instr[24:20], combinationally. Their read data, rs1 and rs2 appear on the execute outputs one edge later.
- R6: The branch (1100011, funct3 000) raises `redirect_o` in the same cycle exactly when the two operands differ. The target is PC plus {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended. The branch writes neither register nor memory.
- R7: jal (1101111) always raises `redirect_o`, with target PC plus {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended, and sets write enable.
- R8: In the cycle after `redirect_o` is high, the incoming instruction is discarded: no redirect, no halt, and 0 on `ex_valid_o` and on all its write/memory controls.
- R9: With `id_valid_i` low, the stage raises no redirect and no halt, and the next execute register has valid and all write/memory controls at 0.
- R10: The word 32'hFFFFFFFF, when live, raises `halt_o` combinationally and enters execute as a bubble (valid 0).
- R11: Any other encoding (for example funct7 0000001 on the register opcode) enters execute as a bubble and raises neither redirect nor halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Instruction in decode is valid (not a nop) |
| id_instr_i | input | 32 | Instruction word |
| id_pc_i | input | PC_W | PC of the instruction |
| rf_raddr1_o | output | 5 | Register file read address, port 1 |
| rf_raddr2_o | output | 5 | Register file read address, port 2 |
| rf_rdata1_i | input | XLEN | Read data, port 1 |
| rf_rdata2_i | input | XLEN | Read data, port 2 |
| redirect_o | output | 1 | Fetch redirect request (taken branch or jump) |
| redirect_pc_o | output | PC_W | Redirect target |
| halt_o | output | 1 | Halt marker decoded |
| ex_valid_o | output | 1 | Execute register holds a live instruction |
| ex_rdata1_o | output | XLEN | Operand 1 |
| ex_rdata2_o | output | XLEN | Operand 2 / store data |
| ex_imm_o | output | XLEN | Sign-extended immediate |
| ex_rs1_o | output | 5 | Source index 1 |
| ex_rs2_o | output | 5 | Source index 2 |
| ex_rd_o | output | 5 | Destination index |
| ex_alu_add_o | output | 1 | 1 add, 0 subtract |
| ex_alu_fn_o | output | 2 | 00 arithmetic, 01 and, 10 or, 11 xor |
| ex_is_itype_o | output | 1 | Second ALU operand is the immediate |
| ex_wr_en_o | output | 1 | Register write enable |
| ex_mem_rd_o | output | 1 | Memory read |
| ex_mem_wr_o | output | 1 | Memory write |

## Verification
The hardest situation to reach is the discard slot. It needs a live branch whose operands differ, or a jump, followed on the very next cycle by a live instruction that would itself redirect, halt or write. Only then does a missing discard show up at the ports. The bench places jumps, halts and stores directly behind taken branches. Its random stream picks the same source register for both branch operands about half the time, so taken and fall-through branches both occur, including back-to-back taken branches.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

    localparam int RA_W = 5;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;

    localparam logic [2:0] F3_ADD   = 3'b000;
    localparam logic [2:0] F3_AND   = 3'b111;
    localparam logic [2:0] F3_OR    = 3'b110;
    localparam logic [2:0] F3_XOR   = 3'b100;
    localparam logic [2:0] F3_DWORD = 3'b011;
    localparam logic [2:0] F3_BR    = 3'b000;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [1:0] {
        FN_ARITH = 2'b00,
        FN_AND   = 2'b01,
        FN_OR    = 2'b10,
        FN_XOR   = 2'b11
    } alu_fn_e;

    typedef enum logic [2:0] {
        IMM_NONE = 3'd0,
        IMM_I    = 3'd1,
        IMM_S    = 3'd2,
        IMM_B    = 3'd3,
        IMM_J    = 3'd4
    } imm_sel_e;

    typedef struct packed {
        logic     legal;
        logic     halt;
        logic     wr_en;
        logic     mem_rd;
        logic     mem_wr;
        logic     alu_add;
        logic     is_itype;
        logic     is_branch;
        logic     is_jal;
        alu_fn_e  alu_fn;
        imm_sel_e imm_sel;
    } dec_ctrl_t;

    // Immediate extractors: 32-bit sign-extended results from the upper word bits.
    function automatic logic [31:0] imm_i(input logic [31:7] w);
        return {{20{w[31]}}, w[31:20]};
    endfunction

    function automatic logic [31:0] imm_s(input logic [31:7] w);
        return {{20{w[31]}}, w[31:25], w[11:7]};
    endfunction

    function automatic logic [31:0] imm_b(input logic [31:7] w);
        return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic [31:0] imm_j(input logic [31:7] w);
        return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endfunction

endpackage

// File: rtl/rvd_ctrl_decode.sv
module rvd_ctrl_decode
    import rvd_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_ctrl_t   ctrl_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = instr_i[6:0];
    assign f3  = instr_i[14:12];
    assign f7  = instr_i[31:25];

    always_comb begin
        ctrl_o = '0;
        if (instr_i == 32'hFFFF_FFFF) begin
            ctrl_o.halt = 1'b1;
        end else begin
            case (opc)
                OPC_REG: begin
                    if (f7 == F7_BASE) begin
                        case (f3)
                            F3_ADD: begin
                                ctrl_o.legal   = 1'b1;
                                ctrl_o.alu_add = 1'b1;
                                ctrl_o.alu_fn  = FN_ARITH;
                            end
                            F3_AND: begin
                                ctrl_o.legal  = 1'b1;
                                ctrl_o.alu_fn = FN_AND;
                            end
                            F3_OR: begin
                                ctrl_o.legal  = 1'b1;
                                ctrl_o.alu_fn = FN_OR;
                            end
                            F3_XOR: begin
                                ctrl_o.legal  = 1'b1;
                                ctrl_o.alu_fn = FN_XOR;
                            end
                            default: ctrl_o.legal = 1'b0;
                        endcase
                    end else if (f7 == F7_ALT && f3 == F3_ADD) begin
                        ctrl_o.legal  = 1'b1;
                        ctrl_o.alu_fn = FN_ARITH;
                    end
                    ctrl_o.wr_en = ctrl_o.legal;
                end
                OPC_IMM: begin
                    if (f3 == F3_ADD) begin
                        ctrl_o.legal    = 1'b1;
                        ctrl_o.wr_en    = 1'b1;
                        ctrl_o.alu_add  = 1'b1;
                        ctrl_o.is_itype = 1'b1;
                        ctrl_o.imm_sel  = IMM_I;
                    end
                end
                OPC_LOAD: begin
                    if (f3 == F3_DWORD) begin
                        ctrl_o.legal    = 1'b1;
                        ctrl_o.wr_en    = 1'b1;
                        ctrl_o.mem_rd   = 1'b1;
                        ctrl_o.alu_add  = 1'b1;
                        ctrl_o.is_itype = 1'b1;
                        ctrl_o.imm_sel  = IMM_I;
                    end
                end
                OPC_STORE: begin
                    if (f3 == F3_DWORD) begin
                        ctrl_o.legal   = 1'b1;
                        ctrl_o.mem_wr  = 1'b1;
                        ctrl_o.alu_add = 1'b1;
                        ctrl_o.imm_sel = IMM_S;
                    end
                end
                OPC_BRANCH: begin
                    if (f3 == F3_BR) begin
                        ctrl_o.legal     = 1'b1;
                        ctrl_o.is_branch = 1'b1;
                        ctrl_o.imm_sel   = IMM_B;
                    end
                end
                OPC_JAL: begin
                    ctrl_o.legal   = 1'b1;
                    ctrl_o.wr_en   = 1'b1;
                    ctrl_o.is_jal  = 1'b1;
                    ctrl_o.imm_sel = IMM_J;
                end
                default: ctrl_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
    import rvd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:7]     word_i,
    input  imm_sel_e        sel_i,
    output logic [XLEN-1:0] imm_o
);
    logic [31:0] raw;

    always_comb begin
        case (sel_i)
            IMM_I:   raw = imm_i(word_i);
            IMM_S:   raw = imm_s(word_i);
            IMM_B:   raw = imm_b(word_i);
            IMM_J:   raw = imm_j(word_i);
            default: raw = '0;
        endcase
    end

    generate
        if (XLEN > 32) begin : g_wide
            assign imm_o = {{(XLEN-32){raw[31]}}, raw};
        end else begin : g_narrow
            assign imm_o = raw[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/rvd_branch_unit.sv
module rvd_branch_unit #(
    parameter int XLEN = 64,
    parameter int PC_W = 32
) (
    input  logic            is_branch_i,
    input  logic            is_jal_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] offset_i,
    output logic            take_o,
    output logic [PC_W-1:0] target_o
);
    logic differ;

    // Inverted-sense conditional: taken on inequality.
    assign differ   = (opa_i != opb_i);
    assign take_o   = is_jal_i | (is_branch_i & differ);
    assign target_o = pc_i + offset_i;
endmodule

// File: rtl/rvd_decode_stage.sv
module rvd_decode_stage
    import rvd_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            id_valid_i,
    input  logic [31:0]     id_instr_i,
    input  logic [PC_W-1:0] id_pc_i,
    output logic [RA_W-1:0] rf_raddr1_o,
    output logic [RA_W-1:0] rf_raddr2_o,
    input  logic [XLEN-1:0] rf_rdata1_i,
    input  logic [XLEN-1:0] rf_rdata2_i,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic            halt_o,
    output logic            ex_valid_o,
    output logic [XLEN-1:0] ex_rdata1_o,
    output logic [XLEN-1:0] ex_rdata2_o,
    output logic [XLEN-1:0] ex_imm_o,
    output logic [RA_W-1:0] ex_rs1_o,
    output logic [RA_W-1:0] ex_rs2_o,
    output logic [RA_W-1:0] ex_rd_o,
    output logic            ex_alu_add_o,
    output logic [1:0]      ex_alu_fn_o,
    output logic            ex_is_itype_o,
    output logic            ex_wr_en_o,
    output logic            ex_mem_rd_o,
    output logic            ex_mem_wr_o
);
    dec_ctrl_t       ctrl;
    logic [XLEN-1:0] imm;
    logic            take;
    logic            squash_q;
    logic            live;

    assign live        = id_valid_i & ~squash_q;
    assign rf_raddr1_o = id_instr_i[19:15];
    assign rf_raddr2_o = id_instr_i[24:20];

    rvd_ctrl_decode u_ctrl (
        .instr_i (id_instr_i),
        .ctrl_o  (ctrl)
    );

    rvd_imm_gen #(.XLEN(XLEN)) u_imm (
        .word_i (id_instr_i[31:7]),
        .sel_i  (ctrl.imm_sel),
        .imm_o  (imm)
    );

    rvd_branch_unit #(.XLEN(XLEN), .PC_W(PC_W)) u_br (
        .is_branch_i (ctrl.is_branch),
        .is_jal_i    (ctrl.is_jal),
        .opa_i       (rf_rdata1_i),
        .opb_i       (rf_rdata2_i),
        .pc_i        (id_pc_i),
        .offset_i    (imm[PC_W-1:0]),
        .take_o      (take),
        .target_o    (redirect_pc_o)
    );

    assign redirect_o = live & take;
    assign halt_o     = live & ctrl.halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            squash_q      <= 1'b0;
            ex_valid_o    <= 1'b0;
            ex_rdata1_o   <= '0;
            ex_rdata2_o   <= '0;
            ex_imm_o      <= '0;
            ex_rs1_o      <= '0;
            ex_rs2_o      <= '0;
            ex_rd_o       <= '0;
            ex_alu_add_o  <= 1'b0;
            ex_alu_fn_o   <= 2'b00;
            ex_is_itype_o <= 1'b0;
            ex_wr_en_o    <= 1'b0;
            ex_mem_rd_o   <= 1'b0;
            ex_mem_wr_o   <= 1'b0;
        end else begin
            squash_q      <= redirect_o;
            ex_valid_o    <= live & ctrl.legal;
            ex_rdata1_o   <= rf_rdata1_i;
            ex_rdata2_o   <= rf_rdata2_i;
            ex_imm_o      <= imm;
            ex_rs1_o      <= id_instr_i[19:15];
            ex_rs2_o      <= id_instr_i[24:20];
            ex_rd_o       <= id_instr_i[11:7];
            ex_alu_add_o  <= ctrl.alu_add;
            ex_alu_fn_o   <= ctrl.alu_fn;
            ex_is_itype_o <= ctrl.is_itype;
            ex_wr_en_o    <= live & ctrl.wr_en;
            ex_mem_rd_o   <= live & ctrl.mem_rd;
            ex_mem_wr_o   <= live & ctrl.mem_wr;
        end
    end
endmodule

// File: rtl/rvd_decode_checker.sv
module rvd_decode_checker (
    input logic clk,
    input logic rst,
    input logic id_valid_i,
    input logic redirect_o,
    input logic halt_o,
    input logic ex_valid_o,
    input logic ex_wr_en_o,
    input logic ex_mem_rd_o,
    input logic ex_mem_wr_o
);
    AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        !id_valid_i |-> (!redirect_o && !halt_o)); // R9

    AST_SQUASH_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> (!redirect_o && !halt_o)); // R8

    AST_SQUASH_SLOT_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> ##1 !ex_valid_o); // R8

    AST_BUBBLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        !ex_valid_o |-> (!ex_wr_en_o && !ex_mem_rd_o && !ex_mem_wr_o)); // R11

    AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        ex_mem_wr_o |-> (!ex_wr_en_o && !ex_mem_rd_o)); // R4

    AST_HALT_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> !redirect_o); // R10

    AST_HALT_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> !ex_valid_o); // R10
endmodule

bind rvd_decode_stage rvd_decode_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .id_valid_i  (id_valid_i),
    .redirect_o  (redirect_o),
    .halt_o      (halt_o),
    .ex_valid_o  (ex_valid_o),
    .ex_wr_en_o  (ex_wr_en_o),
    .ex_mem_rd_o (ex_mem_rd_o),
    .ex_mem_wr_o (ex_mem_wr_o)
);

// File: tb/rvd_decode_stage_tb.sv
`timescale 1ns/1ps
module rvd_decode_stage_tb;
    localparam int XLEN = 64;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            id_valid = 1'b0;
    logic [31:0]     id_instr = 32'h0;
    logic [PC_W-1:0] id_pc = '0;
    logic [4:0]      raddr1, raddr2;
    logic [XLEN-1:0] rdata1, rdata2;
    logic            redirect, halt;
    logic [PC_W-1:0] redirect_pc;
    logic            ex_valid, ex_alu_add, ex_is_itype, ex_wr_en, ex_mem_rd, ex_mem_wr;
    logic [XLEN-1:0] ex_rdata1, ex_rdata2, ex_imm;
    logic [4:0]      ex_rs1, ex_rs2, ex_rd;
    logic [1:0]      ex_alu_fn;

    logic [XLEN-1:0] rf [32];
    assign rdata1 = rf[raddr1];
    assign rdata2 = rf[raddr2];

    always #4 clk = ~clk;

    rvd_decode_stage #(.XLEN(XLEN), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst), .id_valid_i(id_valid), .id_instr_i(id_instr), .id_pc_i(id_pc),
        .rf_raddr1_o(raddr1), .rf_raddr2_o(raddr2), .rf_rdata1_i(rdata1), .rf_rdata2_i(rdata2),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc), .halt_o(halt),
        .ex_valid_o(ex_valid), .ex_rdata1_o(ex_rdata1), .ex_rdata2_o(ex_rdata2), .ex_imm_o(ex_imm),
        .ex_rs1_o(ex_rs1), .ex_rs2_o(ex_rs2), .ex_rd_o(ex_rd), .ex_alu_add_o(ex_alu_add),
        .ex_alu_fn_o(ex_alu_fn), .ex_is_itype_o(ex_is_itype), .ex_wr_en_o(ex_wr_en),
        .ex_mem_rd_o(ex_mem_rd), .ex_mem_wr_o(ex_mem_wr)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    bit m_squash = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference decode, written from the requirement text.
    bit r_legal, r_halt, r_wr, r_mrd, r_mwr, r_add, r_ity, r_br, r_jal;
    logic [1:0]  r_fn;
    logic [63:0] r_imm;

    task automatic ref_decode(input logic [31:0] w);
        logic [6:0] op; logic [2:0] f3; logic [6:0] f7;
        op = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
        {r_legal, r_halt, r_wr, r_mrd, r_mwr, r_add, r_ity, r_br, r_jal} = '0;
        r_fn = 2'b00; r_imm = '0;
        if (w == 32'hFFFF_FFFF) r_halt = 1;
        else if (op == 7'b0110011) begin
            if (f7 == 7'b0 && f3 == 3'b000) begin r_legal = 1; r_add = 1; end
            else if (f7 == 7'b0100000 && f3 == 3'b000) r_legal = 1;
            else if (f7 == 7'b0 && f3 == 3'b111) begin r_legal = 1; r_fn = 2'b01; end
            else if (f7 == 7'b0 && f3 == 3'b110) begin r_legal = 1; r_fn = 2'b10; end
            else if (f7 == 7'b0 && f3 == 3'b100) begin r_legal = 1; r_fn = 2'b11; end
            r_wr = r_legal;
        end else if ((op == 7'b0010011 && f3 == 3'b000) || (op == 7'b0000011 && f3 == 3'b011)) begin
            r_legal = 1; r_wr = 1; r_add = 1; r_ity = 1; r_mrd = (op == 7'b0000011);
            r_imm = {{52{w[31]}}, w[31:20]};
        end else if (op == 7'b0100011 && f3 == 3'b011) begin
            r_legal = 1; r_mwr = 1; r_add = 1;
            r_imm = {{52{w[31]}}, w[31:25], w[11:7]};
        end else if (op == 7'b1100011 && f3 == 3'b000) begin
            r_legal = 1; r_br = 1;
            r_imm = {{51{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        end else if (op == 7'b1101111) begin
            r_legal = 1; r_jal = 1; r_wr = 1;
            r_imm = {{43{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        end
    endtask

    // One decode cycle: drive, check same-cycle outputs, clock, check execute register.
    task automatic step(input bit v, input logic [31:0] w, input logic [31:0] pc, input string req);
        bit live, exp_rd; logic [63:0] a, b; logic [31:0] tgt;
        @(negedge clk);
        id_valid = v; id_instr = w; id_pc = pc;
        #1;
        ref_decode(w);
        live = v && !m_squash;
        a = rf[w[19:15]]; b = rf[w[24:20]];
        exp_rd = live && (r_jal || (r_br && a != b));
        tgt = pc + r_imm[31:0];
        check(raddr1 == w[19:15] && raddr2 == w[24:20], "R5", "raddr", {raddr1, raddr2}, {w[19:15], w[24:20]});
        check(redirect == exp_rd, req, "redirect", redirect, exp_rd);
        if (exp_rd) check(redirect_pc == tgt, req, "target", redirect_pc, tgt);
        check(halt == (live && r_halt), req, "halt", halt, live && r_halt);
        @(posedge clk); #1;
        check(ex_valid == (live && r_legal), req, "ex_valid", ex_valid, live && r_legal);
        check({ex_wr_en, ex_mem_rd, ex_mem_wr} == {live && r_wr, live && r_mrd, live && r_mwr},
              req, "wr/mrd/mwr", {ex_wr_en, ex_mem_rd, ex_mem_wr}, {live && r_wr, live && r_mrd, live && r_mwr});
        if (live && r_legal) begin
            check({ex_alu_add, ex_alu_fn, ex_is_itype} == {r_add, r_fn, r_ity}, req, "alu ctl",
                  {ex_alu_add, ex_alu_fn, ex_is_itype}, {r_add, r_fn, r_ity});
            check(ex_imm == r_imm, req, "imm", ex_imm, r_imm);
            check(ex_rd == w[11:7], req, "rd", ex_rd, w[11:7]);
            check(ex_rdata1 == a && ex_rdata2 == b && ex_rs1 == w[19:15] && ex_rs2 == w[24:20],
                  "R5", "operands", ex_rdata1 ^ ex_rdata2, a ^ b);
        end
        m_squash = exp_rd;
    endtask

    function automatic logic [31:0] mk_r(input logic [6:0] f7, input logic [2:0] f3);
        return {f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), 7'b0110011};
    endfunction

    function automatic logic [31:0] gen(input int k);
        logic [31:0] r; r = $urandom;
        case (k)
            0: return mk_r(7'b0, 3'b000);
            1: return mk_r(7'b0100000, 3'b000);
            2: return mk_r(7'b0, 3'b111);
            3: return mk_r(7'b0, 3'b110);
            4: return mk_r(7'b0, 3'b100);
            5: return {r[31:15], 3'b000, r[11:7], 7'b0010011};
            6: return {r[31:15], 3'b011, r[11:7], 7'b0000011};
            7: return {r[31:15], 3'b011, r[11:7], 7'b0100011};
            8: begin
                if (r[0]) r[24:20] = r[19:15];
                return {r[31:15], 3'b000, r[11:7], 7'b1100011};
            end
            9: return {r[31:7], 7'b1101111};
            10: return 32'hFFFF_FFFF;
            default: return {7'b0000001, r[24:7], 7'b0110011};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        rf[0] = '0;
        for (int i = 1; i < 32; i++) rf[i] = {$urandom, $urandom};
        rf[5] = rf[6];
        repeat (3) @(posedge clk);
        #1;
        check(!ex_valid && !ex_wr_en && !ex_mem_rd && !ex_mem_wr, "R1", "in reset",
              {ex_valid, ex_wr_en, ex_mem_rd, ex_mem_wr}, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(!ex_valid && !ex_wr_en && !ex_mem_rd && !ex_mem_wr, "R1", "after reset",
              {ex_valid, ex_wr_en, ex_mem_rd, ex_mem_wr}, 0);

        // Directed corner cases
        step(1, {7'b0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, 32'h100, "R2");
        step(1, {7'b0100000, 5'd4, 5'd3, 3'b000, 5'd9, 7'b0110011}, 32'h104, "R2");
        step(1, {12'hF80, 5'd7, 3'b000, 5'd8, 7'b0010011}, 32'h108, "R3");
        step(1, {12'h010, 5'd7, 3'b011, 5'd8, 7'b0000011}, 32'h10C, "R3");
        step(1, {7'b1111111, 5'd2, 5'd1, 3'b011, 5'b11000, 7'b0100011}, 32'h110, "R4");
        step(1, {7'b0000000, 5'd6, 5'd5, 3'b000, 5'b01000, 7'b1100011}, 32'h114, "R6");
        step(1, {7'b1111111, 5'd2, 5'd1, 3'b000, 5'b11001, 7'b1100011}, 32'h200, "R6");
        step(1, {20'h0080F, 5'd1, 7'b1101111}, 32'h204, "R8");
        step(1, {7'b0, 5'd2, 5'd1, 3'b011, 5'd4, 7'b0100011}, 32'h1F4, "R4");
        step(1, {20'hFFE01, 5'd1, 7'b1101111}, 32'h300, "R7");
        step(1, 32'hFFFF_FFFF, 32'h304, "R8");
        step(1, {7'b0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1100011}, 32'h400, "R6");
        step(1, {7'b0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1100011}, 32'h404, "R8");
        step(1, 32'hFFFF_FFFF, 32'h500, "R10");
        step(0, {20'h00100, 5'd1, 7'b1101111}, 32'h504, "R9");
        step(0, {7'b0, 5'd2, 5'd1, 3'b011, 5'd4, 7'b0100011}, 32'h508, "R9");
        step(1, {7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, 32'h50C, "R11");
        step(1, {12'h005, 5'd1, 3'b010, 5'd3, 7'b0000011}, 32'h510, "R11");

        // Random stream
        for (int n = 0; n < 400; n++) begin
            int k; bit v;
            k = $urandom_range(0, 11);
            v = ($urandom_range(0, 9) != 0);
            step(v, gen(k), {$urandom_range(0, 16383), 2'b00},
                 k < 5 ? "R2" : k < 7 ? "R3" : k == 7 ? "R4" : k == 8 ? "R6" :
                 k == 9 ? "R7" : k == 10 ? "R10" : "R11");
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule